// File: doc/BRIEF.md
# DDR Read Data Strobe Sequencer

This block models the memory side of a double-data-rate read burst at clock granularity. When a read command strobe is sampled, the block waits a read latency and then drives one or more clock cycles of burst data. The read latency is the sum of an additive latency and a column latency, and the two are programmed independently. Each data cycle carries two elements, one for the rising clock half and one for the falling clock half. The block also produces the matching data-strobe waveform: a one-clock low preamble, then an edge-aligned toggling strobe during the data cycles, then a one-clock low postamble.

The block has no real double-data-rate cells and no tristate pads. High impedance is signalled by separate output-enable bits for the data bus and for the strobe pair. Each clock cycle's strobe level is given as two bits, one per clock half. Burst data is either an internal counter pattern or a pair of words taken from an input port. Back-to-back reads spaced exactly one burst apart stream without any gap on the bus.

Top module: `rd_strobe_seq`

## Requirements
- R1: A read command sampled on clock edge E0 makes the first data cycle the cycle that begins at edge E(RL), where RL = AL_eff + CL_eff. Counting the preamble, the bus stays fully undriven before edge E(RL-1).
- R2: In every data cycle both bits of `dq_valid_o` are 1, so two elements go out per clock. With `data_src_i`=0, beat k of the burst (k from 0) carries `dq_rise_o`=2k and `dq_fall_o`=2k+1. Outside data cycles both data words are 0.
- R3: The `bl8_i` value sampled with the command selects the burst length. 0 gives 4 elements (2 data cycles) and 1 gives 8 elements (4 data cycles).
- R4: The preamble is the single cycle just before the first data cycle of a burst that does not directly follow another burst. In it `dqs_oe_o`=1, `dqs_lvl_o`=2'b00, `dqs_n_lvl_o`=2'b11 and `dq_oe_o`=0.
- R5: During data cycles `dq_oe_o`=1, `dqs_oe_o`=1, `dqs_lvl_o`=2'b01 and `dqs_n_lvl_o`=2'b10. Bit 0 is the first (rising) half and bit 1 is the second half, so the strobe is high with each rising element and low with each falling element.
- R6: The cycle after the last data cycle is a postamble, with `dqs_oe_o`=1, strobe levels as in R4 and `dq_oe_o`=0, unless another burst starts in that cycle. After the postamble, all enables, valids, levels and data are 0.
- R7: A command whose first data cycle falls on the cycle right after the previous burst's last data cycle keeps `dq_oe_o` at 1 with no postamble or preamble in between. The counter pattern restarts at beat 0.
- R8: AL above 4 is used as 4. CL below 3 is used as 3 and CL above 5 as 5. `cfg_err_o` is 1 in the cycle after any edge that samples an out-of-range AL or CL, and 0 otherwise.
- R9: With `data_src_i`=1, data cycles drive `dq_rise_o`=`ext_data_i[7:0]` and `dq_fall_o`=`ext_data_i[15:8]`.
- R10: While `rst_ni` is low and after release with no command, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_cmd_i | input | 1 | Read command strobe, sampled each edge |
| bl8_i | input | 1 | Burst length select, 1 = eight elements |
| al_cfg_i | input | 3 | Additive latency setting |
| cl_cfg_i | input | 3 | Column latency setting |
| data_src_i | input | 1 | 0 = counter pattern, 1 = ext_data_i |
| ext_data_i | input | 16 | External data {fall word, rise word} |
| dq_oe_o | output | 1 | Data bus driven |
| dq_valid_o | output | 2 | Element valid per clock half {fall, rise} |
| dq_rise_o | output | 8 | Rising-half element |
| dq_fall_o | output | 8 | Falling-half element |
| dqs_oe_o | output | 1 | Strobe pair driven |
| dqs_lvl_o | output | 2 | Strobe level per half {second, first} |
| dqs_n_lvl_o | output | 2 | Complement strobe level per half |
| cfg_err_o | output | 1 | Latency setting was out of range |

## Verification
The bench sweeps every AL from 0 to 5 plus 7, every CL from 2 to 6, and both burst lengths. It compares every output in every cycle of a window that covers the whole burst. A latency adder that is off by one, or that drops either term, shifts the data window and fails the first-data check. A wrong clamp shows up only at the out-of-range settings. Back-to-back commands spaced exactly one burst apart expose a design that inserts a postamble/preamble gap or fails to restart the beat pattern. Commands spaced one cycle wider put the first burst's postamble on the same cycle as the second burst's preamble, which catches priority errors between those phases.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int LAT_W  = 3;
  localparam int AL_MAX = 4;
  localparam int CL_MIN = 3;
  localparam int CL_MAX = 5;
  localparam int RL_MAX = AL_MAX + CL_MAX;
  localparam int RL_W   = $clog2(RL_MAX + 1);
  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PRE,
    PH_DATA,
    PH_POST
  } phase_e;
endpackage

// File: rtl/rsq_lat_cfg.sv
module rsq_lat_cfg
  import rsq_pkg::*;
(
  input  logic [LAT_W-1:0] al_i,
  input  logic [LAT_W-1:0] cl_i,
  output logic [RL_W-1:0]  rl_o,
  output logic             err_o
);
  logic [LAT_W-1:0] al_eff, cl_eff;
  logic al_bad, cl_lo, cl_hi;

  always_comb begin
    al_bad = (int'(al_i) > AL_MAX);
    cl_lo  = (int'(cl_i) < CL_MIN);
    cl_hi  = (int'(cl_i) > CL_MAX);
    al_eff = al_bad ? LAT_W'(AL_MAX) : al_i;
    if (cl_lo)      cl_eff = LAT_W'(CL_MIN);
    else if (cl_hi) cl_eff = LAT_W'(CL_MAX);
    else            cl_eff = cl_i;
    rl_o  = RL_W'(al_eff) + RL_W'(cl_eff);
    err_o = al_bad | cl_lo | cl_hi;
  end
endmodule

// File: rtl/rsq_cmd_pipe.sv
module rsq_cmd_pipe
  import rsq_pkg::*;
#(
  parameter int DEPTH = RL_MAX
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_i,
  input  logic            bl8_i,
  input  logic [RL_W-1:0] tap_i,
  output logic            hit_o,
  output logic            hit_bl8_o
);
  logic [DEPTH-1:0] cmd_sr, bl_sr;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic cmd_in, bl_in;
    if (g == 0) begin : g_head
      assign cmd_in = cmd_i;
      assign bl_in  = bl8_i;
    end else begin : g_body
      assign cmd_in = cmd_sr[g-1];
      assign bl_in  = bl_sr[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmd_sr[g] <= 1'b0;
        bl_sr[g]  <= 1'b0;
      end else begin
        cmd_sr[g] <= cmd_in;
        bl_sr[g]  <= cmd_in & bl_in;
      end
    end
  end

  always_comb begin
    hit_o     = 1'b0;
    hit_bl8_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (RL_W'(i) == tap_i) begin
        hit_o     = cmd_sr[i];
        hit_bl8_o = bl_sr[i];
      end
    end
  end
endmodule

// File: rtl/rsq_burst_ctl.sv
module rsq_burst_ctl
  import rsq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              bl8_i,
  output logic              active_o,
  output logic              post_o,
  output logic [BEAT_W-1:0] beat_o
);
  localparam logic [BEAT_W-1:0] LAST4 = BEAT_W'(1);
  localparam logic [BEAT_W-1:0] LAST8 = BEAT_W'(3);

  logic [BEAT_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      post_o   <= 1'b0;
      beat_o   <= '0;
      last_q   <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      post_o   <= 1'b0;
      beat_o   <= '0;
      last_q   <= bl8_i ? LAST8 : LAST4;
    end else if (active_o) begin
      if (beat_o == last_q) begin
        active_o <= 1'b0;
        post_o   <= 1'b1;
        beat_o   <= '0;
      end else begin
        beat_o   <= beat_o + 1'b1;
        post_o   <= 1'b0;
      end
    end else begin
      post_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rsq_strobe_gen.sv
module rsq_strobe_gen
  import rsq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              active_i,
  input  logic              pre_i,
  input  logic              post_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              src_ext_i,
  input  logic [2*DW-1:0]   ext_data_i,
  output logic              dq_oe_o,
  output logic [1:0]        dq_valid_o,
  output logic [DW-1:0]     dq_rise_o,
  output logic [DW-1:0]     dq_fall_o,
  output logic              dqs_oe_o,
  output logic [1:0]        dqs_lvl_o,
  output logic [1:0]        dqs_n_lvl_o
);
  phase_e phase;
  logic [DW-1:0] cnt_rise, cnt_fall;

  always_comb begin
    if (active_i)    phase = PH_DATA;
    else if (pre_i)  phase = PH_PRE;
    else if (post_i) phase = PH_POST;
    else             phase = PH_IDLE;

    cnt_rise = DW'({beat_i, 1'b0});
    cnt_fall = DW'({beat_i, 1'b1});

    dq_oe_o     = 1'b0;
    dq_valid_o  = 2'b00;
    dq_rise_o   = '0;
    dq_fall_o   = '0;
    dqs_oe_o    = 1'b0;
    dqs_lvl_o   = 2'b00;
    dqs_n_lvl_o = 2'b00;
    unique case (phase)
      PH_DATA: begin
        dq_oe_o     = 1'b1;
        dq_valid_o  = 2'b11;
        dq_rise_o   = src_ext_i ? ext_data_i[DW-1:0]    : cnt_rise;
        dq_fall_o   = src_ext_i ? ext_data_i[2*DW-1:DW] : cnt_fall;
        dqs_oe_o    = 1'b1;
        dqs_lvl_o   = 2'b01;
        dqs_n_lvl_o = 2'b10;
      end
      PH_PRE, PH_POST: begin
        dqs_oe_o    = 1'b1;
        dqs_n_lvl_o = 2'b11;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rd_strobe_seq.sv
module rd_strobe_seq
  import rsq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_cmd_i,
  input  logic              bl8_i,
  input  logic [LAT_W-1:0]  al_cfg_i,
  input  logic [LAT_W-1:0]  cl_cfg_i,
  input  logic              data_src_i,
  input  logic [2*DW-1:0]   ext_data_i,
  output logic              dq_oe_o,
  output logic [1:0]        dq_valid_o,
  output logic [DW-1:0]     dq_rise_o,
  output logic [DW-1:0]     dq_fall_o,
  output logic              dqs_oe_o,
  output logic [1:0]        dqs_lvl_o,
  output logic [1:0]        dqs_n_lvl_o,
  output logic              cfg_err_o
);
  logic [RL_W-1:0]   rl, tap;
  logic              err_now, hit, hit_bl8;
  logic              active, post;
  logic [BEAT_W-1:0] beat;

  rsq_lat_cfg u_cfg (
    .al_i (al_cfg_i),
    .cl_i (cl_cfg_i),
    .rl_o (rl),
    .err_o(err_now)
  );

  // stage k holds a command sampled k+1 edges ago; tap RL-1 marks preamble/start
  assign tap = rl - 1'b1;

  rsq_cmd_pipe #(.DEPTH(RL_MAX)) u_pipe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (rd_cmd_i),
    .bl8_i    (bl8_i),
    .tap_i    (tap),
    .hit_o    (hit),
    .hit_bl8_o(hit_bl8)
  );

  rsq_burst_ctl u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (hit),
    .bl8_i   (hit_bl8),
    .active_o(active),
    .post_o  (post),
    .beat_o  (beat)
  );

  rsq_strobe_gen #(.DW(DW)) u_strb (
    .active_i   (active),
    .pre_i      (hit),
    .post_i     (post),
    .beat_i     (beat),
    .src_ext_i  (data_src_i),
    .ext_data_i (ext_data_i),
    .dq_oe_o    (dq_oe_o),
    .dq_valid_o (dq_valid_o),
    .dq_rise_o  (dq_rise_o),
    .dq_fall_o  (dq_fall_o),
    .dqs_oe_o   (dqs_oe_o),
    .dqs_lvl_o  (dqs_lvl_o),
    .dqs_n_lvl_o(dqs_n_lvl_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_err_o <= 1'b0;
    else         cfg_err_o <= err_now;
  end
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker
  import rsq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LAT_W-1:0] al_cfg_i,
  input logic [LAT_W-1:0] cl_cfg_i,
  input logic             dq_oe_o,
  input logic [1:0]       dq_valid_o,
  input logic             dqs_oe_o,
  input logic [1:0]       dqs_lvl_o,
  input logic [1:0]       dqs_n_lvl_o,
  input logic             cfg_err_o
);
  assert_data_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (dqs_oe_o && dqs_lvl_o == 2'b01 && dqs_n_lvl_o == 2'b10 && dq_valid_o == 2'b11));

  assert_postamble_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dq_oe_o) |-> (dqs_oe_o && dqs_lvl_o == 2'b00 && dqs_n_lvl_o == 2'b11));

  assert_preamble_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> ($past(dqs_oe_o) && $past(dqs_lvl_o) == 2'b00));

  assert_cfg_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(al_cfg_i) > AL_MAX || int'(cl_cfg_i) < CL_MIN || int'(cl_cfg_i) > CL_MAX) |=> cfg_err_o);

  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dqs_oe_o |-> (!dq_oe_o && dq_valid_o == 2'b00 && dqs_lvl_o == 2'b00 && dqs_n_lvl_o == 2'b00));
endmodule

bind rd_strobe_seq rsq_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .al_cfg_i   (al_cfg_i),
  .cl_cfg_i   (cl_cfg_i),
  .dq_oe_o    (dq_oe_o),
  .dq_valid_o (dq_valid_o),
  .dqs_oe_o   (dqs_oe_o),
  .dqs_lvl_o  (dqs_lvl_o),
  .dqs_n_lvl_o(dqs_n_lvl_o),
  .cfg_err_o  (cfg_err_o)
);

// File: tb/sim_rd_strobe_seq.sv
`timescale 1ns/1ps
module sim_rd_strobe_seq;
  logic clk = 0, rst_n = 0;
  logic rd_cmd = 0, bl8 = 0, src = 0;
  logic [2:0] al = 0, cl = 3;
  logic [15:0] ext = 16'h5AA5;
  logic dq_oe, dqs_oe, cfg_err;
  logic [1:0] dq_valid, dqs_lvl, dqs_n_lvl;
  logic [7:0] dq_rise, dq_fall;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rd_strobe_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .rd_cmd_i(rd_cmd), .bl8_i(bl8),
    .al_cfg_i(al), .cl_cfg_i(cl), .data_src_i(src), .ext_data_i(ext),
    .dq_oe_o(dq_oe), .dq_valid_o(dq_valid), .dq_rise_o(dq_rise), .dq_fall_o(dq_fall),
    .dqs_oe_o(dqs_oe), .dqs_lvl_o(dqs_lvl), .dqs_n_lvl_o(dqs_n_lvl), .cfg_err_o(cfg_err)
  );

  function automatic logic [24:0] outs();
    return {dq_oe, dq_valid, dqs_oe, dqs_lvl, dqs_n_lvl, dq_rise, dq_fall, cfg_err};
  endfunction

  task automatic check(string tag, logic [24:0] act, logic [24:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one or two commands at cycles 0 and c2 (c2<0: none); window n = cycle after edge En
  task automatic run(int a, int c, bit b8, bit s, int c2);
    int rl, bc, ncyc;
    bit err;
    al = 3'(a); cl = 3'(c); bl8 = b8; src = s;
    err = (a > 4) || (c < 3) || (c > 5);
    rl = (a > 4 ? 4 : a) + (c < 3 ? 3 : (c > 5 ? 5 : c));
    bc = b8 ? 4 : 2;
    ncyc = rl + 2 * bc + 6;
    @(negedge clk); rd_cmd = 1;
    @(posedge clk);
    for (int n = 0; n < ncyc; n++) begin
      logic [24:0] e;
      bit dat, pre, post;
      int beat;
      string tag;
      @(negedge clk);
      rd_cmd = (c2 >= 0) && (n + 1 == c2);
      dat = 0; pre = 0; post = 0; beat = 0;
      for (int k = 0; k < 2; k++) begin
        int t;
        t = (k == 0) ? 0 : c2;
        if (k == 1 && c2 < 0) continue;
        if (n >= t + rl && n < t + rl + bc) begin dat = 1; beat = n - t - rl; end
        if (n == t + rl - 1) pre = 1;
        if (n == t + rl + bc) post = 1;
      end
      e = '0;
      e[0] = err;
      if (dat) begin
        e[24] = 1; e[23:22] = 2'b11; e[21] = 1; e[20:19] = 2'b01; e[18:17] = 2'b10;
        e[16:9] = s ? ext[7:0] : 8'(2 * beat);
        e[8:1]  = s ? ext[15:8] : 8'(2 * beat + 1);
        tag = s ? "R9 ext data" : (n == rl ? "R1/R2/R5 first data" : "R2/R3/R5/R7 data");
      end else if (pre || post) begin
        e[21] = 1; e[18:17] = 2'b11;
        tag = (pre && post) ? "R6/R4 post+pre overlap" : (pre ? "R4 preamble" : "R6 postamble");
      end else tag = (n < rl) ? "R1 latency idle" : "R6/R3 idle after burst";
      if (err) tag = {tag, " R8 clamp"};
      check($sformatf("%s al=%0d cl=%0d bl8=%0d c2=%0d n=%0d", tag, a, c, b8, c2, n), outs(), e);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #5000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R10 in reset", outs(), '0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R10 after reset idle", outs(), '0);
    for (int a = 0; a <= 7; a++) begin
      if (a == 6) continue;
      for (int c = 2; c <= 6; c++)
        for (int b = 0; b < 2; b++) run(a, c, b[0], 1'b0, -1);
    end
    run(1, 3, 1'b0, 1'b0, 2);   // R7 seamless BL4
    run(2, 4, 1'b1, 1'b0, 4);   // R7 seamless BL8
    run(0, 5, 1'b0, 1'b0, 3);   // R6/R4 overlap
    run(4, 3, 1'b1, 1'b0, 5);
    run(1, 3, 1'b0, 1'b1, -1);  // R9
    ext = 16'hC33C;
    run(3, 5, 1'b1, 1'b1, 4);   // R9 with R7
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule